// File: doc/BRIEF.md
# Exception Sequencer with Interrupt-Enable Save and Restore

This block sits beside the execute stage of a small 32-bit core. Each cycle it takes event strobes for the instruction in flight: an unsigned divide or modulo with a zero divisor, a system call, a breakpoint, a data access that hit an unmapped or misaligned address, and a register-indirect branch that may be a return from a handler. From these it produces three things: the next program counter, a write of the faulting PC into a link register (30 for normal exceptions, 31 for the debug breakpoint), and the update of the three-bit interrupt-enable register.

Normal exceptions and the breakpoint each save the live enable in a slot of their own, so a breakpoint taken inside a handler does not lose the handler's saved state. The block also holds four control registers. The pending-interrupt register is set by interrupt sources and cleared by writing ones to it. The enable register and the two handler base registers are plain write registers. Both base registers keep their low eight bits at zero, so every 32-byte vector slot stays aligned.

The sequencer is a four-state machine whose state records what the previous cycle decided. In ST_SEQ, execution is sequential. ST_EXC means a normal exception was taken, ST_DBG means a breakpoint was taken, and ST_RET means a branch is being redirected. Every cycle, from any state, the arbiter's decision picks the next state:
- a normal exception goes to ST_EXC;
- a breakpoint goes to ST_DBG;
- a return branch goes to ST_RET;
- anything else goes to ST_SEQ.

The outputs are registered and appear in the cycle after the event.

Top module: `trap_sequencer`

## Requirements
- R1: A normal exception drives outputs in the next cycle: `redirect_o`=1, `link_we_o`=1, `link_idx_o`=30 and `link_data_o` = the event cycle's `pc_i`. `next_pc_o` is the base held in the normal-handler register (read in the event cycle) plus ID×32. The IDs are: data bus error 4, divide by zero 5, system call 7.
- R2: A breakpoint drives, in the next cycle, `redirect_o`=1, `link_we_o`=1, `link_idx_o`=30+1=31, `link_data_o` = the event PC, and `next_pc_o` = debug base + 1×32.
- R3: A normal exception sets the enable register to {0, old bit0, 0}.
- R4: A breakpoint sets the enable register to {old bit0, 0, 0}.
- R5: When `ret_i` is taken, the next cycle shows `redirect_o`=1, `link_we_o`=0 and `next_pc_o`=`ret_target_i`. If `ret_reg_i`=30, the enable register becomes {0,0,old bit1}. If it is 31, the register becomes {0,0,old bit2}. For any other register the enable register is unchanged.
- R6: Only one event is taken per cycle, in the priority order data bus error, divide by zero, system call, breakpoint, return.
- R7: A CSR write with `csr_sel_i`=1 (pending) clears every pending bit that is 1 in the data and keeps the others. Bits of `irq_set_i` are then ORed in.
- R8: A CSR write replaces the enable register (`csr_sel_i`=0, data bits 2:0), the normal base (2) or the debug base (3). The base registers keep their bits 7:0 at zero. An enable update from an event in the same cycle takes precedence over a CSR write to the enable register.
- R9: A cycle with no event, including a divide with a nonzero divisor, gives `redirect_o`=0, `link_we_o`=0 and `next_pc_o` = that cycle's `pc_i`+4 in the next cycle.
- R10: Reset clears the enable register, the pending register and both bases, and leaves `redirect_o`=0 and `link_we_o`=0.
- R11: An unmapped access and a misaligned access each raise the same data-bus-error exception, with ID 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | PC of the instruction in execute |
| div_op_i | input | 1 | Divide or modulo executes this cycle |
| div_zero_i | input | 1 | Divisor of that operation is zero |
| scall_i | input | 1 | System-call instruction |
| break_i | input | 1 | Breakpoint instruction |
| bus_unmapped_i | input | 1 | Data access to an unmapped address |
| bus_misaligned_i | input | 1 | Misaligned data access |
| ret_i | input | 1 | Register-indirect branch |
| ret_reg_i | input | 5 | Register index used by that branch |
| ret_target_i | input | 32 | Branch target address |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 2 | CSR select: 0 enable, 1 pending, 2 normal base, 3 debug base |
| csr_wdata_i | input | 32 | CSR write data |
| irq_set_i | input | 8 | Interrupt lines that set pending bits |
| redirect_o | output | 1 | Next PC is not sequential |
| next_pc_o | output | 32 | Next program counter |
| link_we_o | output | 1 | Link register write |
| link_idx_o | output | 5 | Link register index |
| link_data_o | output | 32 | Saved faulting PC |
| ie_o | output | 3 | Enable register: bit0 live, bit1 normal save, bit2 debug save |
| ip_o | output | 8 | Pending register |
| eba_o | output | 32 | Normal handler base |
| deba_o | output | 32 | Debug handler base |

## Verification
The bench fires strobes together to check the priority ranking and the rule that only one event is taken. A wrong ranking would vector to the wrong slot or save into the wrong link register. It runs nested exception, breakpoint and return sequences with different enable patterns. A design that shared one save slot, or shifted the wrong bit, would restore an enable that does not match the reference. Writes to the pending register that land in the same cycle as a raised interrupt line, writes of unaligned base values, and enable writes that collide with an event show whether clear-on-one, bit masking and update precedence are correct. A return through a register other than 30 or 31 must leave the enable register untouched.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        ST_SEQ = 2'd0,
        ST_EXC = 2'd1,
        ST_DBG = 2'd2,
        ST_RET = 2'd3
    } trap_state_e;

    typedef enum logic [2:0] {
        IE_KEEP  = 3'd0,
        IE_EXC   = 3'd1,
        IE_DBG   = 3'd2,
        IE_RET_E = 3'd3,
        IE_RET_D = 3'd4
    } ie_op_e;

    localparam logic [1:0] CSR_IE   = 2'd0;
    localparam logic [1:0] CSR_IP   = 2'd1;
    localparam logic [1:0] CSR_EBA  = 2'd2;
    localparam logic [1:0] CSR_DEBA = 2'd3;

    localparam logic [2:0] EID_RESET = 3'd0;
    localparam logic [2:0] EID_BRK   = 3'd1;
    localparam logic [2:0] EID_IBE   = 3'd2;
    localparam logic [2:0] EID_WATCH = 3'd3;
    localparam logic [2:0] EID_DBE   = 3'd4;
    localparam logic [2:0] EID_DVZ   = 3'd5;
    localparam logic [2:0] EID_IRQ   = 3'd6;
    localparam logic [2:0] EID_SCALL = 3'd7;

    localparam logic [4:0] LINK_EXC = 5'd30;
    localparam logic [4:0] LINK_DBG = 5'd31;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic       bus_unmapped_i,
    input  logic       bus_misaligned_i,
    input  logic       div_op_i,
    input  logic       div_zero_i,
    input  logic       scall_i,
    input  logic       break_i,
    input  logic       ret_i,
    input  logic [4:0] ret_reg_i,
    output logic       take_exc_o,
    output logic       take_dbg_o,
    output logic       take_ret_o,
    output logic [2:0] eid_o,
    output ie_op_e     ie_op_o
);
    logic dbe, dvz;

    assign dbe = bus_unmapped_i | bus_misaligned_i;
    assign dvz = div_op_i & div_zero_i;

    always_comb begin
        take_exc_o = 1'b0;
        take_dbg_o = 1'b0;
        take_ret_o = 1'b0;
        eid_o      = EID_RESET;
        ie_op_o    = IE_KEEP;
        if (dbe) begin
            take_exc_o = 1'b1;
            eid_o      = EID_DBE;
            ie_op_o    = IE_EXC;
        end else if (dvz) begin
            take_exc_o = 1'b1;
            eid_o      = EID_DVZ;
            ie_op_o    = IE_EXC;
        end else if (scall_i) begin
            take_exc_o = 1'b1;
            eid_o      = EID_SCALL;
            ie_op_o    = IE_EXC;
        end else if (break_i) begin
            take_dbg_o = 1'b1;
            eid_o      = EID_BRK;
            ie_op_o    = IE_DBG;
        end else if (ret_i) begin
            take_ret_o = 1'b1;
            if (ret_reg_i == LINK_EXC)
                ie_op_o = IE_RET_E;
            else if (ret_reg_i == LINK_DBG)
                ie_op_o = IE_RET_D;
        end
    end

endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
    import trap_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NIRQ       = 8,
    parameter int BASE_ALIGN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ie_op_e          ie_op_i,
    input  logic            csr_we_i,
    input  logic [1:0]      csr_sel_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    input  logic [NIRQ-1:0] irq_set_i,
    output logic [2:0]      ie_o,
    output logic [NIRQ-1:0] ip_o,
    output logic [XLEN-1:0] eba_o,
    output logic [XLEN-1:0] deba_o
);
    localparam int HI_W = XLEN - BASE_ALIGN;
    localparam logic [XLEN-1:0] BASE_MASK = {{HI_W{1'b1}}, {BASE_ALIGN{1'b0}}};
    localparam int NBASE = 2;

    logic [2:0]      ie_q, ie_d;
    logic [NIRQ-1:0] ip_q, ip_d;
    logic [XLEN-1:0] base_q [NBASE];

    always_comb begin
        ie_d = ie_q;
        unique case (ie_op_i)
            IE_EXC:   ie_d = {1'b0, ie_q[0], 1'b0};
            IE_DBG:   ie_d = {ie_q[0], 2'b00};
            IE_RET_E: ie_d = {2'b00, ie_q[1]};
            IE_RET_D: ie_d = {2'b00, ie_q[2]};
            default: begin
                if (csr_we_i && csr_sel_i == CSR_IE)
                    ie_d = csr_wdata_i[2:0];
            end
        endcase
    end

    always_comb begin
        ip_d = ip_q;
        if (csr_we_i && csr_sel_i == CSR_IP)
            ip_d = ip_q & ~csr_wdata_i[NIRQ-1:0];
        ip_d = ip_d | irq_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= '0;
            ip_q <= '0;
        end else begin
            ie_q <= ie_d;
            ip_q <= ip_d;
        end
    end

    for (genvar gi = 0; gi < NBASE; gi++) begin : g_base
        localparam logic [1:0] SEL = (gi == 0) ? CSR_EBA : CSR_DEBA;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                base_q[gi] <= '0;
            else if (csr_we_i && csr_sel_i == SEL)
                base_q[gi] <= csr_wdata_i & BASE_MASK;
        end
    end

    assign ie_o   = ie_q;
    assign ip_o   = ip_q;
    assign eba_o  = base_q[0];
    assign deba_o = base_q[1];

endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
    import trap_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int VEC_SHIFT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pc_i,
    input  logic            take_exc_i,
    input  logic            take_dbg_i,
    input  logic            take_ret_i,
    input  logic [2:0]      eid_i,
    input  logic [XLEN-1:0] ret_target_i,
    input  logic [XLEN-1:0] eba_i,
    input  logic [XLEN-1:0] deba_i,
    output logic            redirect_o,
    output logic [XLEN-1:0] next_pc_o,
    output logic            link_we_o,
    output logic [4:0]      link_idx_o,
    output logic [XLEN-1:0] link_data_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    trap_state_e     state_q, state_d;
    logic [XLEN-1:0] target_q, target_d;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] slot_off;

    assign slot_off = XLEN'(eid_i) << VEC_SHIFT;

    // next-state and target selection
    always_comb begin
        state_d  = ST_SEQ;
        target_d = pc_i + STEP;
        if (take_exc_i) begin
            state_d  = ST_EXC;
            target_d = eba_i + slot_off;
        end else if (take_dbg_i) begin
            state_d  = ST_DBG;
            target_d = deba_i + slot_off;
        end else if (take_ret_i) begin
            state_d  = ST_RET;
            target_d = ret_target_i;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_SEQ;
            target_q <= STEP;
            pc_q     <= '0;
        end else begin
            state_q  <= state_d;
            target_q <= target_d;
            pc_q     <= pc_i;
        end
    end

    // outputs decoded from state
    always_comb begin
        redirect_o  = 1'b0;
        link_we_o   = 1'b0;
        link_idx_o  = LINK_EXC;
        next_pc_o   = target_q;
        link_data_o = pc_q;
        unique case (state_q)
            ST_SEQ: ;
            ST_EXC: begin
                redirect_o = 1'b1;
                link_we_o  = 1'b1;
            end
            ST_DBG: begin
                redirect_o = 1'b1;
                link_we_o  = 1'b1;
                link_idx_o = LINK_DBG;
            end
            ST_RET: redirect_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trap_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NIRQ       = 8,
    parameter int BASE_ALIGN = 8,
    parameter int VEC_SHIFT  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pc_i,
    input  logic            div_op_i,
    input  logic            div_zero_i,
    input  logic            scall_i,
    input  logic            break_i,
    input  logic            bus_unmapped_i,
    input  logic            bus_misaligned_i,
    input  logic            ret_i,
    input  logic [4:0]      ret_reg_i,
    input  logic [XLEN-1:0] ret_target_i,
    input  logic            csr_we_i,
    input  logic [1:0]      csr_sel_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    input  logic [NIRQ-1:0] irq_set_i,
    output logic            redirect_o,
    output logic [XLEN-1:0] next_pc_o,
    output logic            link_we_o,
    output logic [4:0]      link_idx_o,
    output logic [XLEN-1:0] link_data_o,
    output logic [2:0]      ie_o,
    output logic [NIRQ-1:0] ip_o,
    output logic [XLEN-1:0] eba_o,
    output logic [XLEN-1:0] deba_o
);
    logic       take_exc, take_dbg, take_ret;
    logic [2:0] eid;
    ie_op_e     ie_op;

    trap_arbiter u_arb (
        .bus_unmapped_i   (bus_unmapped_i),
        .bus_misaligned_i (bus_misaligned_i),
        .div_op_i         (div_op_i),
        .div_zero_i       (div_zero_i),
        .scall_i          (scall_i),
        .break_i          (break_i),
        .ret_i            (ret_i),
        .ret_reg_i        (ret_reg_i),
        .take_exc_o       (take_exc),
        .take_dbg_o       (take_dbg),
        .take_ret_o       (take_ret),
        .eid_o            (eid),
        .ie_op_o          (ie_op)
    );

    trap_csr_file #(.XLEN(XLEN), .NIRQ(NIRQ), .BASE_ALIGN(BASE_ALIGN)) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ie_op_i     (ie_op),
        .csr_we_i    (csr_we_i),
        .csr_sel_i   (csr_sel_i),
        .csr_wdata_i (csr_wdata_i),
        .irq_set_i   (irq_set_i),
        .ie_o        (ie_o),
        .ip_o        (ip_o),
        .eba_o       (eba_o),
        .deba_o      (deba_o)
    );

    trap_fsm #(.XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pc_i         (pc_i),
        .take_exc_i   (take_exc),
        .take_dbg_i   (take_dbg),
        .take_ret_i   (take_ret),
        .eid_i        (eid),
        .ret_target_i (ret_target_i),
        .eba_i        (eba_o),
        .deba_i       (deba_o),
        .redirect_o   (redirect_o),
        .next_pc_o    (next_pc_o),
        .link_we_o    (link_we_o),
        .link_idx_o   (link_idx_o),
        .link_data_o  (link_data_o)
    );

endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
    parameter int XLEN = 32,
    parameter int NIRQ = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc_i,
    input logic            div_op_i,
    input logic            div_zero_i,
    input logic            scall_i,
    input logic            break_i,
    input logic            bus_unmapped_i,
    input logic            bus_misaligned_i,
    input logic            ret_i,
    input logic            csr_we_i,
    input logic [1:0]      csr_sel_i,
    input logic [XLEN-1:0] csr_wdata_i,
    input logic [NIRQ-1:0] irq_set_i,
    input logic            redirect_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic            link_we_o,
    input logic [4:0]      link_idx_o,
    input logic [XLEN-1:0] link_data_o,
    input logic [2:0]      ie_o,
    input logic [NIRQ-1:0] ip_o,
    input logic [XLEN-1:0] eba_o,
    input logic [XLEN-1:0] deba_o
);
    logic normal_evt, any_evt;
    assign normal_evt = bus_unmapped_i | bus_misaligned_i | (div_op_i & div_zero_i) | scall_i;
    assign any_evt    = normal_evt | break_i | ret_i;

    AST_EXC_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        normal_evt |=> link_we_o && link_idx_o == 5'd30 && link_data_o == $past(pc_i)); // R1
    AST_DBG_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (break_i && !normal_evt) |=> link_we_o && link_idx_o == 5'd31 && link_data_o == $past(pc_i)); // R2
    AST_EXC_IE: assert property (@(posedge clk) disable iff (!rst_n)
        normal_evt |=> ie_o == {1'b0, $past(ie_o[0]), 1'b0}); // R3
    AST_DBG_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (break_i && !normal_evt) |=> ie_o == {$past(ie_o[0]), 2'b00}); // R4
    AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> next_pc_o[4:0] == 5'd0 && redirect_o); // R1
    AST_IP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && csr_sel_i == 2'd1 && irq_set_i == '0) |=> ip_o == ($past(ip_o) & ~$past(csr_wdata_i[NIRQ-1:0]))); // R7
    AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        eba_o[7:0] == 8'd0 && deba_o[7:0] == 8'd0); // R8
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !any_evt |=> !redirect_o && !link_we_o && next_pc_o == $past(pc_i) + 32'd4); // R9

endmodule

bind trap_sequencer trap_sequencer_chk #(.XLEN(XLEN), .NIRQ(NIRQ)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .pc_i             (pc_i),
    .div_op_i         (div_op_i),
    .div_zero_i       (div_zero_i),
    .scall_i          (scall_i),
    .break_i          (break_i),
    .bus_unmapped_i   (bus_unmapped_i),
    .bus_misaligned_i (bus_misaligned_i),
    .ret_i            (ret_i),
    .csr_we_i         (csr_we_i),
    .csr_sel_i        (csr_sel_i),
    .csr_wdata_i      (csr_wdata_i),
    .irq_set_i        (irq_set_i),
    .redirect_o       (redirect_o),
    .next_pc_o        (next_pc_o),
    .link_we_o        (link_we_o),
    .link_idx_o       (link_idx_o),
    .link_data_o      (link_data_o),
    .ie_o             (ie_o),
    .ip_o             (ip_o),
    .eba_o            (eba_o),
    .deba_o           (deba_o)
);

// File: tb/trap_sequencer_tb.sv
`timescale 1ns/1ps
module trap_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic        div_op_i = 0, div_zero_i = 0, scall_i = 0, break_i = 0;
    logic        bus_unmapped_i = 0, bus_misaligned_i = 0, ret_i = 0;
    logic [4:0]  ret_reg_i = '0;
    logic [31:0] ret_target_i = '0;
    logic        csr_we_i = 0;
    logic [1:0]  csr_sel_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic [7:0]  irq_set_i = '0;
    logic        redirect_o, link_we_o;
    logic [31:0] next_pc_o, link_data_o, eba_o, deba_o;
    logic [4:0]  link_idx_o;
    logic [2:0]  ie_o;
    logic [7:0]  ip_o;

    always #4 clk = ~clk;

    trap_sequencer u_dut (.*);

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // reference model state
    logic [2:0]  m_ie = 0;
    logic [7:0]  m_ip = 0;
    logic [31:0] m_eba = 0, m_deba = 0, m_npc = 4, m_ldata = 0;
    bit          m_redir = 0, m_lwe = 0, m_valid = 0;
    int          m_lidx = 30;
    string       m_tag = "R10", m_ietag = "R10";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ie = 0; m_ip = 0; m_eba = 0; m_deba = 0;
            m_redir = 0; m_lwe = 0; m_npc = 4; m_tag = "R10"; m_ietag = "R10";
            m_valid = 1;
        end else begin
            int nev;
            bit dbe, dvz, iechg;
            logic [2:0] ie_old;
            dbe = bus_unmapped_i | bus_misaligned_i;
            dvz = div_op_i & div_zero_i;
            nev = int'(dbe) + int'(dvz) + int'(scall_i) + int'(break_i) + int'(ret_i);
            ie_old = m_ie; iechg = 0; m_ietag = "R8";
            if (dbe || dvz || scall_i) begin
                int id;
                id = dbe ? 4 : (dvz ? 5 : 7);
                m_redir = 1; m_lwe = 1; m_lidx = 30; m_ldata = pc_i;
                m_npc = m_eba + 32'(id * 32);
                m_ie = {1'b0, ie_old[0], 1'b0}; iechg = 1;
                m_tag = dbe ? "R11" : "R1"; m_ietag = "R3";
            end else if (break_i) begin
                m_redir = 1; m_lwe = 1; m_lidx = 31; m_ldata = pc_i;
                m_npc = m_deba + 32'd32;
                m_ie = {ie_old[0], 2'b00}; iechg = 1;
                m_tag = "R2"; m_ietag = "R4";
            end else if (ret_i) begin
                m_redir = 1; m_lwe = 0; m_npc = ret_target_i;
                if (ret_reg_i == 30) begin m_ie = {2'b00, ie_old[1]}; iechg = 1; end
                else if (ret_reg_i == 31) begin m_ie = {2'b00, ie_old[2]}; iechg = 1; end
                m_tag = "R5"; m_ietag = "R5";
            end else begin
                m_redir = 0; m_lwe = 0; m_npc = pc_i + 4; m_tag = "R9";
            end
            if (nev > 1) m_tag = "R6";
            if (csr_we_i) begin
                case (csr_sel_i)
                    2'd0: if (!iechg) m_ie = csr_wdata_i[2:0];
                    2'd1: m_ip = m_ip & ~csr_wdata_i[7:0];
                    2'd2: m_eba = {csr_wdata_i[31:8], 8'h00};
                    default: m_deba = {csr_wdata_i[31:8], 8'h00};
                endcase
            end
            m_ip = m_ip | irq_set_i;
        end
    end

    always @(negedge clk) begin
        if (m_valid && rst_n && !done) begin
            chk(redirect_o == m_redir, m_tag, "redirect", 32'(redirect_o), 32'(m_redir));
            chk(next_pc_o == m_npc, m_tag, "next_pc", next_pc_o, m_npc);
            chk(link_we_o == m_lwe, m_tag, "link_we", 32'(link_we_o), 32'(m_lwe));
            if (m_lwe) begin
                chk(link_idx_o == 5'(m_lidx), m_tag, "link_idx", 32'(link_idx_o), 32'(m_lidx));
                chk(link_data_o == m_ldata, m_tag, "link_data", link_data_o, m_ldata);
            end
            chk(ie_o == m_ie, m_ietag, "ie", 32'(ie_o), 32'(m_ie));
            chk(ip_o == m_ip, "R7", "ip", 32'(ip_o), 32'(m_ip));
            chk(eba_o == m_eba, "R8", "eba", eba_o, m_eba);
            chk(deba_o == m_deba, "R8", "deba", deba_o, m_deba);
        end
    end

    task automatic idle();
        div_op_i = 0; div_zero_i = 0; scall_i = 0; break_i = 0;
        bus_unmapped_i = 0; bus_misaligned_i = 0; ret_i = 0;
        csr_we_i = 0; irq_set_i = 0;
    endtask

    task automatic step();
        @(negedge clk); #1;
        idle();
        pc_i = pc_i + 4;
    endtask

    task automatic csr(input logic [1:0] sel, input logic [31:0] d);
        step(); csr_we_i = 1; csr_sel_i = sel; csr_wdata_i = d;
    endtask

    task automatic ret_via(input logic [4:0] r, input logic [31:0] t);
        step(); ret_i = 1; ret_reg_i = r; ret_target_i = t;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(ie_o == 0, "R10", "ie", 32'(ie_o), 0);
        chk(ip_o == 0, "R10", "ip", 32'(ip_o), 0);
        chk(eba_o == 0 && deba_o == 0, "R10", "bases", eba_o | deba_o, 0);
        chk(!redirect_o && !link_we_o, "R10", "redirect/link", 32'({redirect_o, link_we_o}), 0);
        #1 rst_n = 1;
        pc_i = 32'h0000_0100;
        csr(2'd2, 32'h1000_00ff);       // R8 low bits masked
        csr(2'd3, 32'h2000_01a5);
        csr(2'd0, 32'h0000_0001);
        step(); scall_i = 1;            // R1 syscall
        ret_via(5'd30, 32'h0000_0200);  // R5
        step(); break_i = 1;            // R2
        ret_via(5'd31, 32'h0000_0300);
        step(); div_op_i = 1; div_zero_i = 1;   // R1 divide by zero
        step(); div_op_i = 1;           // R9 nonzero divisor
        step(); bus_unmapped_i = 1;     // R11
        step(); bus_misaligned_i = 1;   // R11
        step(); bus_misaligned_i = 1; break_i = 1; scall_i = 1; // R6
        step(); div_op_i = 1; div_zero_i = 1; scall_i = 1;      // R6
        step(); scall_i = 1; break_i = 1; ret_i = 1;            // R6
        step(); break_i = 1; ret_i = 1; ret_reg_i = 30;         // R6
        // nested: exception then breakpoint then returns
        csr(2'd0, 32'h0000_0001);
        step(); scall_i = 1;
        step(); break_i = 1;
        ret_via(5'd31, 32'h0000_0400);
        ret_via(5'd30, 32'h0000_0500);
        ret_via(5'd5, 32'h0000_0600);   // R5 other register leaves IE
        // IE write colliding with an event (R8)
        step(); scall_i = 1; csr_we_i = 1; csr_sel_i = 0; csr_wdata_i = 32'h7;
        step(); ret_i = 1; ret_reg_i = 7; csr_we_i = 1; csr_sel_i = 0; csr_wdata_i = 32'h5;
        // R7 pending
        step(); irq_set_i = 8'hf3;
        csr(2'd1, 32'h0000_0031);
        step(); csr_we_i = 1; csr_sel_i = 1; csr_wdata_i = 32'h0000_00ff; irq_set_i = 8'h80;
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            step();
            pc_i = $urandom & 32'hffff_fffc;
            bus_unmapped_i   = ($urandom % 16) == 0;
            bus_misaligned_i = ($urandom % 16) == 0;
            div_op_i         = ($urandom % 4) == 0;
            div_zero_i       = ($urandom % 2) == 0;
            scall_i          = ($urandom % 8) == 0;
            break_i          = ($urandom % 8) == 0;
            ret_i            = ($urandom % 5) == 0;
            ret_reg_i        = 5'(28 + ($urandom % 4));
            ret_target_i     = $urandom;
            csr_we_i         = ($urandom % 4) == 0;
            csr_sel_i        = 2'($urandom);
            csr_wdata_i      = $urandom;
            irq_set_i        = ($urandom % 3) == 0 ? 8'($urandom) : 8'h00;
        end
        step(); step();
        @(negedge clk); #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule